// File: doc/BRIEF.md
# Single-Frame Snooping Coherence Controller

This block keeps one cached block frame coherent with other caches on a shared bus. It behaves like a one-line, direct-mapped cache. The line holds a tag (the full block address), one data word and one of three states: Invalid, Shared (readable only) or Exclusive (readable and writable). Coherence is kept by write-invalidate. A processor that wants to write must first announce a write miss on the bus, and every other copy of that block is then dropped.

The processor side is a valid/ready port. A request is taken when `cpu_valid` and `cpu_ready` are both high in the same cycle. While `cpu_ready` is low, the requester must hold `cpu_write`, `cpu_addr` and `cpu_wdata` stable. A hit that needs no bus traffic completes in the cycle it is presented. Any other access first requests the bus and performs its transaction(s) one per grant. It then retries internally and completes as a hit.

The snoop side watches the requests that other caches put on the bus. It acts only on read misses and write misses whose address equals the stored tag of a valid line. When a snoop acts on the line, it takes the line for that cycle and the processor side stalls. Memory and the arbiter sit outside the block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset the line is Invalid, and `bus_req`, `bus_valid`, `flush_valid` and `cpu_ready` are low, so the first access of any kind misses.
- R2: A read whose address equals the tag of a Shared or Exclusive line completes with `cpu_ready` high in the cycle it is presented. `cpu_rdata` carries the stored word and there is no bus transaction.
- R3: A write that hits an Exclusive line completes in the cycle it is presented. It updates the stored word, and there is no bus transaction.
- R4: A write that hits a Shared line issues one bus transaction of type write miss (code 2) for that address. The line becomes Exclusive and the write then completes.
- R5: A read miss issues one bus transaction of type read miss (code 1) for the requested address. The controller waits for `fill_valid`, stores `fill_data`, marks the line Shared and returns the filled word.
- R6: A write miss issues one write miss (code 2) and needs no fill. The line becomes Exclusive, holding the written word.
- R7: On a miss while the line is Exclusive, a write-back (code 3) carrying the old tag and the old word comes first. The line goes Invalid, and only then is the read or write miss issued.
- R8: A snooped read miss (code 1) that matches an Exclusive line raises `flush_valid` in the same cycle with the stored word. The line drops to Shared, so a later write hit needs a bus write miss.
- R9: A snooped write miss (code 2) that matches a Shared or Exclusive line invalidates it. `flush_valid` carries the word only if the line was Exclusive.
- R10: A snoop whose address differs from the tag, a snoop of type none (0) or write-back (3), and a snooped read miss to a Shared line raise no flush and leave the line unchanged.
- R11: In a cycle where a snoop acts on the line, `cpu_ready` and `bus_valid` stay low. The processor access is then decided against the line state after the snoop.
- R12: `bus_valid` is high only in cycles with `bus_gnt` high. `bus_req` stays high until granted, unless a snoop changes the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the access |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read word, meaningful with cpu_ready on a read |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_valid | output | 1 | Bus transaction placed this cycle |
| bus_op | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_data | output | DATA_W | Write-back or write-miss word |
| fill_valid | input | 1 | Memory returns the block for a read miss |
| fill_data | input | DATA_W | Returned word |
| snp_valid | input | 1 | Another cache's bus request is visible |
| snp_op | input | 2 | Snooped request type, same codes as bus_op |
| snp_addr | input | ADDR_W | Snooped address |
| flush_valid | output | 1 | This cache supplies or writes back its word |
| flush_data | output | DATA_W | Supplied word |

## Verification
The embedded properties watch the handshakes that hold on every cycle. A bus strobe only under grant. A held request. The processor locked out while a snoop acts. The state left behind by a granted write-back, a write miss, a fill, an Exclusive write hit or a flush. The full transaction order (write-back before the miss, the upgrade on a Shared write hit, no traffic on hits) shows only in the bench scenarios. So do the flushed and returned words and the snoop that overtakes a pending access. The bench compares each access and each snoop with a reference model of line and memory.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BOP_NONE = 2'd0,
    BOP_RDM  = 2'd1,
    BOP_WRM  = 2'd2,
    BOP_WB   = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_WBACK = 2'd1,
    PS_REQ   = 2'd2,
    PS_FILL  = 2'd3
  } proc_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_inv,
  input  logic              snp_dng,
  input  logic              set_st_en,
  input  line_st_e          set_st,
  input  logic              set_tag_en,
  input  logic [ADDR_W-1:0] set_tag,
  input  logic              set_data_en,
  input  logic [DATA_W-1:0] set_data,
  output line_st_e          st,
  output logic [ADDR_W-1:0] tag,
  output logic [DATA_W-1:0] data
);
  // snoop updates win over processor-side updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= LS_INV;
    end else if (snp_inv) begin
      st <= LS_INV;
    end else if (snp_dng) begin
      st <= LS_SHD;
    end else if (set_st_en) begin
      st <= set_st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag  <= '0;
      data <= '0;
    end else begin
      if (set_tag_en)  tag  <= set_tag;
      if (set_data_en) data <= set_data;
    end
  end

  assert_snp_inv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inv |=> st == LS_INV);
  assert_snp_dng_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_dng && !snp_inv) |=> st == LS_SHD);
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_e          st,
  input  logic [ADDR_W-1:0] tag,
  input  logic [DATA_W-1:0] data,
  output logic              snp_act,
  output logic              snp_inv,
  output logic              snp_dng,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  logic match, rd_hit, wr_hit;

  always_comb begin
    match       = snp_valid && (st != LS_INV) && (tag == snp_addr);
    rd_hit      = match && (snp_op == BOP_RDM) && (st == LS_EXC);
    wr_hit      = match && (snp_op == BOP_WRM);
    snp_dng     = rd_hit;
    snp_inv     = wr_hit;
    snp_act     = rd_hit || wr_hit;
    flush_valid = rd_hit || (wr_hit && st == LS_EXC);
    flush_data  = flush_valid ? data : '0;
  end
endmodule

// File: rtl/coh_proc_fsm.sv
module coh_proc_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_act,
  input  line_st_e          st,
  input  logic [ADDR_W-1:0] tag,
  input  logic [DATA_W-1:0] data,
  output logic              set_st_en,
  output line_st_e          set_st,
  output logic              set_tag_en,
  output logic [ADDR_W-1:0] set_tag,
  output logic              set_data_en,
  output logic [DATA_W-1:0] set_data
);
  proc_st_e ps, ps_n;
  bus_op_e  req_op, req_op_n, op_d;
  logic     hit, granted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps     <= PS_IDLE;
      req_op <= BOP_NONE;
    end else begin
      ps     <= ps_n;
      req_op <= req_op_n;
    end
  end

  always_comb begin
    hit         = (st != LS_INV) && (tag == cpu_addr);
    granted     = bus_gnt && !snp_act;
    ps_n        = ps;
    req_op_n    = req_op;
    cpu_ready   = 1'b0;
    bus_req     = 1'b0;
    bus_valid   = 1'b0;
    op_d        = BOP_NONE;
    bus_addr    = '0;
    bus_data    = '0;
    set_st_en   = 1'b0;
    set_st      = LS_INV;
    set_tag_en  = 1'b0;
    set_tag     = cpu_addr;
    set_data_en = 1'b0;
    set_data    = cpu_wdata;
    case (ps)
      PS_IDLE: begin
        if (cpu_valid && !snp_act) begin
          if (hit && (!cpu_write || st == LS_EXC)) begin
            cpu_ready   = 1'b1;
            set_data_en = cpu_write;
          end else if (hit) begin
            req_op_n = BOP_WRM;
            ps_n     = PS_REQ;
          end else begin
            req_op_n = cpu_write ? BOP_WRM : BOP_RDM;
            ps_n     = (st == LS_EXC) ? PS_WBACK : PS_REQ;
          end
        end
      end
      PS_WBACK: begin
        if (st != LS_EXC) begin
          ps_n = PS_REQ;  // a snoop already flushed the victim
        end else begin
          bus_req  = 1'b1;
          op_d     = BOP_WB;
          bus_addr = tag;
          bus_data = data;
          if (granted) begin
            bus_valid = 1'b1;
            set_st_en = 1'b1;
            set_st    = LS_INV;
            ps_n      = PS_REQ;
          end
        end
      end
      PS_REQ: begin
        bus_req  = 1'b1;
        op_d     = req_op;
        bus_addr = cpu_addr;
        bus_data = (req_op == BOP_WRM) ? cpu_wdata : '0;
        if (granted) begin
          bus_valid = 1'b1;
          if (req_op == BOP_WRM) begin
            set_st_en  = 1'b1;
            set_st     = LS_EXC;
            set_tag_en = 1'b1;
            ps_n       = PS_IDLE;
          end else begin
            ps_n = PS_FILL;
          end
        end
      end
      PS_FILL: begin
        if (fill_valid && !snp_act) begin
          set_st_en   = 1'b1;
          set_st      = LS_SHD;
          set_tag_en  = 1'b1;
          set_data_en = 1'b1;
          set_data    = fill_data;
          ps_n        = PS_IDLE;
        end
      end
      default: ps_n = PS_IDLE;
    endcase
    bus_op    = bus_valid ? op_d : BOP_NONE;
    cpu_rdata = data;
  end

  assert_gnt_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_gnt);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_valid && !snp_act) |=> bus_req);
  assert_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_act |-> (!cpu_ready && !bus_valid));
  assert_wb_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_op == BOP_WB) |=> st == LS_INV);
  assert_wrm_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_op == BOP_WRM) |=> (st == LS_EXC && tag == $past(cpu_addr)));
  assert_fill_shd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ps == PS_FILL && fill_valid && !snp_act) |=> (st == LS_SHD && data == $past(fill_data)));
  assert_wr_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_write) |=> (data == $past(cpu_wdata) && st == LS_EXC));
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  line_st_e          st, set_st;
  logic [ADDR_W-1:0] tag, set_tag;
  logic [DATA_W-1:0] data, set_data;
  logic              snp_act, snp_inv, snp_dng;
  logic              set_st_en, set_tag_en, set_data_en;

  coh_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_line (
    .clk(clk), .rst_n(rst_n), .snp_inv(snp_inv), .snp_dng(snp_dng),
    .set_st_en(set_st_en), .set_st(set_st), .set_tag_en(set_tag_en),
    .set_tag(set_tag), .set_data_en(set_data_en), .set_data(set_data),
    .st(st), .tag(tag), .data(data)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .st(st), .tag(tag), .data(data), .snp_act(snp_act),
    .snp_inv(snp_inv), .snp_dng(snp_dng),
    .flush_valid(flush_valid), .flush_data(flush_data)
  );

  coh_proc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_proc (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr),
    .bus_data(bus_data), .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_act(snp_act), .st(st), .tag(tag), .data(data),
    .set_st_en(set_st_en), .set_st(set_st), .set_tag_en(set_tag_en),
    .set_tag(set_tag), .set_data_en(set_data_en), .set_data(set_data)
  );

  assert_flush_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> st != LS_EXC);
  assert_rd_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_write) |-> (st != LS_INV && !bus_req));
endmodule

// File: tb/snoop_coh_ctrl_tb.sv
module snoop_coh_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, bus_req, bus_valid, flush_valid;
  logic [DW-1:0] cpu_rdata, bus_data, flush_data;
  logic [1:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 1'b0, fill_valid = 1'b0, snp_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;
  logic [1:0] snp_op = '0;
  logic [AW-1:0] snp_addr = '0;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;  // 50 MHz

  snoop_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr),
    .bus_data(bus_data), .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .flush_valid(flush_valid), .flush_data(flush_data)
  );

  // reference model: 0 invalid, 1 shared, 2 exclusive
  int m_st = 0;
  logic [AW-1:0] m_tag = '0;
  logic [DW-1:0] m_data = '0;
  logic [DW-1:0] mem [logic [AW-1:0]];
  int exp_n, obs_n;
  logic [1:0] exp_op [4];
  logic [1:0] obs_op [4];
  logic [AW-1:0] exp_ad [4];
  logic [AW-1:0] obs_ad [4];
  logic [DW-1:0] exp_dt [4];
  logic [DW-1:0] obs_dt [4];

  function automatic logic [DW-1:0] memrd(logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return {a ^ 16'h5A3C, a};
  endfunction

  task automatic check(bit ok, string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic void push(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    exp_op[exp_n] = op; exp_ad[exp_n] = a; exp_dt[exp_n] = d; exp_n++;
  endfunction

  function automatic void model_snoop(logic [1:0] op, logic [AW-1:0] a,
                                      output bit act, output bit fv, output logic [DW-1:0] fd,
                                      output string rq);
    bit match = (m_st != 0) && (m_tag == a);
    act = 0; fv = 0; fd = '0; rq = "R10";
    if (match && op == 2'd1 && m_st == 2) begin
      act = 1; fv = 1; fd = m_data; mem[a] = m_data; m_st = 1; rq = "R8";
    end else if (match && op == 2'd2) begin
      act = 1; rq = "R9";
      if (m_st == 2) begin fv = 1; fd = m_data; mem[a] = m_data; end
      m_st = 0;
    end
  endfunction

  function automatic void model_access(bit w, logic [AW-1:0] a, logic [DW-1:0] wd,
                                       output string rq, output logic [DW-1:0] erd);
    bit hit = (m_st != 0) && (m_tag == a);
    exp_n = 0; erd = '0;
    if (hit && !w) begin
      rq = "R2"; erd = m_data;
    end else if (hit && m_st == 2) begin
      rq = "R3"; m_data = wd;
    end else if (hit) begin
      rq = "R4"; push(2'd2, a, '0); m_st = 2; m_data = wd;
    end else begin
      rq = w ? "R6" : "R5";
      if (m_st == 2) begin
        rq = "R7"; push(2'd3, m_tag, m_data); mem[m_tag] = m_data;
      end
      m_tag = a;
      if (w) begin push(2'd2, a, '0); m_st = 2; m_data = wd; end
      else begin push(2'd1, a, '0); m_data = memrd(a); m_st = 1; erd = m_data; end
    end
  endfunction

  task automatic run_access(bit w, logic [AW-1:0] a, logic [DW-1:0] wd,
                            bit with_snp, logic [1:0] sop, logic [AW-1:0] sa);
    string rq, srq;
    logic [DW-1:0] erd, got_rd, sfd;
    bit sact, sfv, done, fill_pend, no_gnt_strobe;
    logic [AW-1:0] fill_addr;
    int cyc;
    sact = 0; sfv = 0; sfd = '0; srq = "R11";
    if (with_snp) model_snoop(sop, sa, sact, sfv, sfd, srq);
    model_access(w, a, wd, rq, erd);
    obs_n = 0; done = 0; fill_pend = 0; fill_addr = '0; cyc = 0;
    no_gnt_strobe = 1; got_rd = '0;
    @(negedge clk);
    cpu_valid = 1; cpu_write = w; cpu_addr = a; cpu_wdata = wd;
    if (with_snp) begin snp_valid = 1; snp_op = sop; snp_addr = sa; end
    while (!done && cyc < 200) begin
      bus_gnt = bus_req && ($urandom_range(0, 2) != 0);
      fill_valid = fill_pend && ($urandom_range(0, 1) == 1);
      fill_data = memrd(fill_addr);
      #5;
      if (with_snp && cyc == 0) begin
        check(flush_valid == sfv, srq, "flush strobe with pending access", {31'd0, flush_valid}, {31'd0, sfv});
        if (sact) check(!cpu_ready, "R11", "processor stalled under snoop", {31'd0, cpu_ready}, 32'd0);
      end
      if (bus_valid && !bus_gnt) no_gnt_strobe = 0;
      if (bus_valid && obs_n < 4) begin
        obs_op[obs_n] = bus_op; obs_ad[obs_n] = bus_addr; obs_dt[obs_n] = bus_data; obs_n++;
        if (bus_op == 2'd1) begin fill_pend = 1; fill_addr = bus_addr; end
      end
      if (fill_valid) fill_pend = 0;
      if (cpu_ready) begin done = 1; got_rd = cpu_rdata; end
      @(negedge clk);
      cyc++;
      snp_valid = 0;
    end
    cpu_valid = 0; bus_gnt = 0; fill_valid = 0;
    check(done, rq, "access completed before watchdog", {31'd0, done}, 32'd1);
    check(no_gnt_strobe, "R12", "bus strobe only under grant", {31'd0, no_gnt_strobe}, 32'd1);
    check(obs_n == exp_n, rq, "bus transaction count", obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      check(obs_op[i] == exp_op[i], rq, "bus op", {30'd0, obs_op[i]}, {30'd0, exp_op[i]});
      check(obs_ad[i] == exp_ad[i], rq, "bus addr", {16'd0, obs_ad[i]}, {16'd0, exp_ad[i]});
      if (exp_op[i] == 2'd3)
        check(obs_dt[i] == exp_dt[i], "R7", "write-back word", obs_dt[i], exp_dt[i]);
    end
    if (!w) check(got_rd == erd, rq, "read word", got_rd, erd);
  endtask

  task automatic run_snoop(logic [1:0] op, logic [AW-1:0] a);
    bit act, fv;
    logic [DW-1:0] fd;
    string rq;
    model_snoop(op, a, act, fv, fd, rq);
    @(negedge clk);
    snp_valid = 1; snp_op = op; snp_addr = a;
    #5;
    check(flush_valid == fv, rq, "flush strobe", {31'd0, flush_valid}, {31'd0, fv});
    if (fv) check(flush_data == fd, rq, "flush word", flush_data, fd);
    check(!bus_valid, rq, "no bus strobe on snoop", {31'd0, bus_valid}, 32'd0);
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #3000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!bus_req && !bus_valid && !flush_valid && !cpu_ready, "R1", "idle outputs after reset",
          {28'd0, bus_req, bus_valid, flush_valid, cpu_ready}, 32'd0);
    // directed corner cases
    run_access(0, 16'h0010, '0, 0, 2'd0, '0);           // R5 first read misses (R1)
    run_access(0, 16'h0010, '0, 0, 2'd0, '0);           // R2
    run_access(1, 16'h0010, 32'hCAFE0001, 0, 2'd0, '0); // R4
    run_access(1, 16'h0010, 32'hCAFE0002, 0, 2'd0, '0); // R3
    run_access(0, 16'h0011, '0, 0, 2'd0, '0);           // R7 victim write-back
    run_access(1, 16'h0012, 32'h12345678, 0, 2'd0, '0); // R6
    run_snoop(2'd1, 16'h0012);                          // R8
    run_snoop(2'd1, 16'h0012);                          // R10 shared read
    run_access(1, 16'h0012, 32'h0BADF00D, 0, 2'd0, '0); // R4 after downgrade
    run_snoop(2'd2, 16'h0013);                          // R10 other address
    run_snoop(2'd3, 16'h0012);                          // R10 write-back type
    run_snoop(2'd2, 16'h0012);                          // R9 exclusive flush
    run_access(1, 16'h0010, 32'h77777777, 0, 2'd0, '0);
    run_access(0, 16'h0010, '0, 1, 2'd2, 16'h0010);     // R11 snoop overtakes hit
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = 16'h0010 + 16'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 7)
        run_access(1'($urandom_range(0, 1)), a, $urandom(), ($urandom_range(0, 7) == 0),
                   2'($urandom_range(0, 3)), 16'h0010 + 16'($urandom_range(0, 3)));
      else
        run_snoop(2'($urandom_range(0, 3)), a);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule